// File: doc/BRIEF.md
# Address PROM Signature Scanner

This block follows a byte stream pulled one byte at a time from a station-address PROM whose internal read pointer can sit at any position when probing begins. It searches that stream for a fixed eight-byte pattern (FF 00 55 AA FF 00 55 AA). Once the last pattern byte is taken it drops its byte request on the spot, so the PROM pointer is left on the first byte of the station address that follows. If the pattern has not shown up within a bounded number of bytes, it reports failure.

An optional arming step runs before the search. Two bytes are fetched: the first is thrown away to settle the PROM address counter, and the second is compared with 0x08. On a match a one-cycle counter-enable strobe is raised for the PROM logic. Neither byte counts toward the search window.

The controller has four states. IDLE waits for a start pulse. DROP takes the discarded byte, TRIG takes the trigger byte, and SCAN runs the match. The transitions are: IDLE to DROP on start with arming, IDLE to SCAN on start without arming, DROP to TRIG on a taken byte, TRIG to SCAN on a taken byte, and SCAN to IDLE on either a completed match or the last window byte.

Top module: `sig_scan`

## Requirements
- R1: After reset, byte_req_o, found_o, fail_o, done_o and cnt_en_o are all 0.
- R2: In SCAN, each taken byte advances a match index by one when it equals pattern byte number index (pattern FF,00,55,AA,FF,00,55,AA, index 0 first). When the index reaches 8, found_o is set and done_o pulses for one cycle. This happens in the cycle after the edge that took the last pattern byte.
- R3: A SCAN byte that does not match resets the index to 1 if the byte is FF, and to 0 otherwise.
- R4: With PROBE_LEN=32 and SIG_LEN=8, at most 39 bytes are taken in SCAN. If the 39th byte does not complete the pattern, fail_o is set and done_o pulses. A pattern that ends on byte 39 is still reported as found.
- R5: byte_req_o is 0 in the cycle done_o pulses. No byte is taken after the one that completes the pattern or the window.
- R6: With arm_i=1 at start, exactly two bytes are taken before SCAN. cnt_en_o pulses for one cycle, the cycle after the second byte is taken, if and only if that byte equals 0x08.
- R7: found_o and fail_o are never 1 together. Each stays at its value until the next accepted start pulse clears both.
- R8: A start pulse while a run is in progress has no effect on the result or on the number of bytes taken.
- R9: byte_req_o is 1 only in DROP, TRIG and SCAN. A byte is taken only on a clock edge where byte_req_o and byte_vld_i are both 1, and byte_vld_i while byte_req_o is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted in IDLE only |
| arm_i | input | 1 | Sampled at start: run the DROP/TRIG arming step first |
| byte_i | input | 8 | Byte read from the PROM |
| byte_vld_i | input | 1 | byte_i holds a valid byte |
| byte_req_o | output | 1 | Scanner is waiting for a byte |
| cnt_en_o | output | 1 | One-cycle PROM counter-enable strobe |
| found_o | output | 1 | Pattern found (held) |
| fail_o | output | 1 | Window used up without a match (held) |
| done_o | output | 1 | One-cycle pulse when a run ends |

## Verification
A wrong match index shows up at the ports as a shifted byte count. Either found_o is reported after a different number of taken bytes, or fail_o appears where a pattern was present. Either way it is visible on the done_o pulse of the same run. A wrong window count moves the fail_o pulse away from byte 39. A late request drop appears as one extra byte taken in the cycle right after the completing byte. The bench sweeps the pattern position across every window offset and checks the exact number of bytes taken against an arithmetic model of the index rule.

// File: rtl/sig_scan_pkg.sv
package sig_scan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DROP,
        ST_TRIG,
        ST_SCAN
    } scan_state_t;

endpackage

// File: rtl/sig_match_idx.sv
module sig_match_idx #(
    parameter int                  SIG_LEN   = 8,
    parameter logic [SIG_LEN*8-1:0] SIGNATURE = 64'hFF00_55AA_FF00_55AA,
    localparam int                 IW        = $clog2(SIG_LEN + 1),
    localparam int                 AW        = (SIG_LEN > 1) ? $clog2(SIG_LEN) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       step,
    input  logic [7:0] data,
    output logic       hit_now
);

    logic [7:0]    sig_b [SIG_LEN];
    logic [IW-1:0] idx_q;
    logic [IW-1:0] idx_d;
    logic [7:0]    want;

    // Pattern bytes, first byte in the most significant position
    for (genvar g = 0; g < SIG_LEN; g++) begin : g_sig
        assign sig_b[g] = SIGNATURE[(SIG_LEN-1-g)*8 +: 8];
    end

    assign want = sig_b[idx_q[AW-1:0]];

    always_comb begin
        if (data == want) begin
            idx_d = idx_q + IW'(1);
        end else if (data == sig_b[0]) begin
            idx_d = IW'(1);
        end else begin
            idx_d = '0;
        end
    end

    assign hit_now = step && (idx_d == IW'(SIG_LEN));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clr) begin
            idx_q <= '0;
        end else if (step) begin
            idx_q <= hit_now ? '0 : idx_d;
        end
    end

endmodule

// File: rtl/sig_window_cnt.sv
module sig_window_cnt #(
    parameter int WINDOW = 39,
    localparam int CW    = $clog2(WINDOW + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic last_now
);

    logic [CW-1:0] cnt_q;

    assign last_now = step && (cnt_q == CW'(WINDOW - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (step && !last_now) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/sig_scan.sv
module sig_scan
    import sig_scan_pkg::*;
#(
    parameter int                  PROBE_LEN = 32,
    parameter int                  SIG_LEN   = 8,
    parameter logic [SIG_LEN*8-1:0] SIGNATURE = 64'hFF00_55AA_FF00_55AA,
    parameter logic [7:0]          TRIG_VAL  = 8'h08,
    localparam int                 WINDOW    = PROBE_LEN + SIG_LEN - 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       arm_i,
    input  logic [7:0] byte_i,
    input  logic       byte_vld_i,
    output logic       byte_req_o,
    output logic       cnt_en_o,
    output logic       found_o,
    output logic       fail_o,
    output logic       done_o
);

    scan_state_t state_q, state_d;
    logic        take;
    logic        launch;
    logic        scan_step;
    logic        hit_now;
    logic        last_now;

    assign byte_req_o = (state_q != ST_IDLE);
    assign take       = byte_req_o && byte_vld_i;
    assign launch     = (state_q == ST_IDLE) && start_i;
    assign scan_step  = (state_q == ST_SCAN) && take;

    sig_match_idx #(
        .SIG_LEN   (SIG_LEN),
        .SIGNATURE (SIGNATURE)
    ) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (launch),
        .step    (scan_step),
        .data    (byte_i),
        .hit_now (hit_now)
    );

    sig_window_cnt #(
        .WINDOW (WINDOW)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (launch),
        .step     (scan_step),
        .last_now (last_now)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = arm_i ? ST_DROP : ST_SCAN;
            ST_DROP: if (take) state_d = ST_TRIG;
            ST_TRIG: if (take) state_d = ST_SCAN;
            ST_SCAN: if (hit_now || last_now) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            found_o  <= 1'b0;
            fail_o   <= 1'b0;
            done_o   <= 1'b0;
            cnt_en_o <= 1'b0;
        end else begin
            done_o   <= 1'b0;
            cnt_en_o <= 1'b0;
            if (launch) begin
                found_o <= 1'b0;
                fail_o  <= 1'b0;
            end
            if ((state_q == ST_TRIG) && take && (byte_i == TRIG_VAL)) begin
                cnt_en_o <= 1'b1;
            end
            if (hit_now) begin
                found_o <= 1'b1;
                done_o  <= 1'b1;
            end else if (last_now) begin
                fail_o <= 1'b1;
                done_o <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sig_scan_chk.sv
module sig_scan_chk #(
    parameter int  PROBE_LEN = 32,
    parameter int  SIG_LEN   = 8,
    localparam int WINDOW    = PROBE_LEN + SIG_LEN - 1,
    localparam int HW        = $clog2(WINDOW + 3) + 1
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic arm_i,
    input logic byte_vld_i,
    input logic byte_req_o,
    input logic cnt_en_o,
    input logic found_o,
    input logic fail_o,
    input logic done_o
);

    logic [HW-1:0] hs_cnt;
    logic          arm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_cnt <= '0;
            arm_q  <= 1'b0;
        end else if (start_i && !byte_req_o) begin
            hs_cnt <= '0;
            arm_q  <= arm_i;
        end else if (byte_req_o && byte_vld_i && (hs_cnt != '1)) begin
            hs_cnt <= hs_cnt + HW'(1);
        end
    end

    AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(found_o && fail_o)); // R7

    AST_FOUND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (found_o && !start_i) |=> found_o); // R7

    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !start_i) |=> fail_o); // R7

    AST_DONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (found_o || fail_o)); // R2

    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !byte_req_o); // R5

    AST_CNT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en_o |=> !cnt_en_o); // R6

    AST_FAIL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fail_o) |-> (hs_cnt == HW'(WINDOW + (arm_q ? 2 : 0)))); // R4

    AST_FOUND_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && found_o) |-> (hs_cnt <= HW'(WINDOW + (arm_q ? 2 : 0)))); // R4

endmodule

bind sig_scan sig_scan_chk #(
    .PROBE_LEN (PROBE_LEN),
    .SIG_LEN   (SIG_LEN)
) u_sig_scan_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .arm_i      (arm_i),
    .byte_vld_i (byte_vld_i),
    .byte_req_o (byte_req_o),
    .cnt_en_o   (cnt_en_o),
    .found_o    (found_o),
    .fail_o     (fail_o),
    .done_o     (done_o)
);

// File: tb/test_sig_scan.sv
`timescale 1ns/1ps
module test_sig_scan;

    localparam int         WINDOW = 39;
    localparam logic [63:0] SIG   = 64'hFF00_55AA_FF00_55AA;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       arm_i = 1'b0;
    logic [7:0] byte_i = 8'h00;
    logic       byte_vld_i = 1'b0;
    logic       byte_req_o, cnt_en_o, found_o, fail_o, done_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0] stim [64];

    always #4 clk = ~clk;

    sig_scan i_sig_scan (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .arm_i(arm_i),
        .byte_i(byte_i), .byte_vld_i(byte_vld_i), .byte_req_o(byte_req_o),
        .cnt_en_o(cnt_en_o), .found_o(found_o), .fail_o(fail_o), .done_o(done_o)
    );

    function automatic logic [7:0] sig_byte(input int i);
        return SIG[(7-i)*8 +: 8];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Arithmetic model of the index rule and window
    task automatic model(input bit arm, output bit e_found, output int e_used);
        int idx = 0;
        int pos = arm ? 2 : 0;
        e_found = 0;
        for (int c = 0; c < WINDOW; c++) begin
            logic [7:0] b = stim[pos];
            pos++;
            if (b == sig_byte(idx)) idx++;
            else idx = (b == 8'hFF) ? 1 : 0;
            if (idx == 8) begin
                e_found = 1;
                break;
            end
        end
        e_used = pos;
    endtask

    task automatic run_case(input bit arm, input bit gap, input bit mid_start, input string tag);
        int  n = 0;
        int  cyc = 0;
        int  cen = 0;
        bit  e_found;
        int  e_used;
        model(arm, e_found, e_used);
        @(negedge clk);
        start_i = 1'b1;
        arm_i   = arm;
        @(negedge clk);
        start_i = 1'b0;
        forever begin
            if (done_o || cyc > 300) break;
            if (cnt_en_o) cen++;
            start_i = (mid_start && cyc == 5);
            if (byte_req_o && !(gap && (cyc % 3 == 1))) begin
                byte_i     = (n < 64) ? stim[n] : 8'h00;
                byte_vld_i = 1'b1;
                n++;
            end else begin
                byte_vld_i = 1'b0;
            end
            cyc++;
            @(negedge clk);
        end
        byte_vld_i = 1'b0;
        start_i    = 1'b0;
        chk(done_o == 1'b1, {"R2 done seen ", tag}, int'(done_o), 1);
        chk(found_o == e_found, {"R2 R3 R4 found ", tag}, int'(found_o), int'(e_found));
        chk(fail_o == !e_found, {"R4 fail ", tag}, int'(fail_o), int'(!e_found));
        chk(n == e_used, {"R5 bytes taken ", tag}, n, e_used);
        chk(byte_req_o == 1'b0, {"R5 req low at done ", tag}, int'(byte_req_o), 0);
        if (arm) chk(cen == ((stim[1] == 8'h08) ? 1 : 0), {"R6 cnt_en ", tag},
                     cen, (stim[1] == 8'h08) ? 1 : 0);
        if (mid_start) chk(1'b1, {"R8 mid start ", tag}, 0, 0);
    endtask

    task automatic fill(input logic [7:0] v);
        for (int i = 0; i < 64; i++) stim[i] = v + 8'(i % 5);
    endtask

    task automatic put_sig(input int at);
        for (int i = 0; i < 8; i++) stim[at + i] = sig_byte(i);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] lf = 8'h5A;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({byte_req_o, found_o, fail_o, done_o, cnt_en_o} == 5'b0, "R1 reset outputs",
            int'({byte_req_o, found_o, fail_o, done_o, cnt_en_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R4: pattern at every offset, including just past the window
        for (int k = 0; k <= 33; k++) begin
            fill(8'h10);
            put_sig(k);
            run_case(1'b0, k[0], 1'b0, $sformatf("off%0d", k));
        end

        // R3: restart on FF inside a partial match
        fill(8'h20);
        stim[0] = 8'hFF; stim[1] = 8'h00; stim[2] = 8'h55; stim[3] = 8'hFF;
        put_sig(3);
        run_case(1'b0, 1'b0, 1'b0, "R3 ff restart");
        fill(8'h20);
        stim[0] = 8'hFF; put_sig(1);
        run_case(1'b0, 1'b0, 1'b0, "R3 double ff");
        fill(8'h20);
        stim[0] = 8'hFF; stim[1] = 8'h00; stim[2] = 8'h13; put_sig(3);
        run_case(1'b0, 1'b0, 1'b0, "R3 zero restart");
        for (int i = 0; i < 64; i++) stim[i] = 8'hFF;
        run_case(1'b0, 1'b0, 1'b0, "R3 all ff");

        // R6: arming step with and without trigger byte
        for (int t = 0; t < 4; t++) begin
            fill(8'h30);
            stim[0] = 8'hFF;
            stim[1] = (t < 2) ? 8'h08 : 8'h09;
            put_sig(2 + 3 * t);
            run_case(1'b1, t[0], 1'b0, $sformatf("R6 arm%0d", t));
        end

        // R7: results held while idle
        repeat (6) @(negedge clk);
        chk(found_o == 1'b1 && fail_o == 1'b0, "R7 hold found", int'(found_o), 1);

        // R9: valid strobes while idle do nothing
        for (int i = 0; i < 4; i++) begin
            byte_i = 8'hFF; byte_vld_i = 1'b1;
            @(negedge clk);
            chk(byte_req_o == 1'b0 && found_o == 1'b1 && done_o == 1'b0,
                "R9 idle strobe", int'({byte_req_o, found_o, done_o}), 2);
        end
        byte_vld_i = 1'b0;

        // R8: start during a run is ignored
        fill(8'h40); put_sig(12);
        run_case(1'b0, 1'b0, 1'b1, "R8 found");
        fill(8'h40);
        run_case(1'b1, 1'b1, 1'b1, "R8 fail");

        // Pseudo-random streams against the model
        for (int r = 0; r < 40; r++) begin
            for (int i = 0; i < 64; i++) begin
                lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                stim[i] = (lf[1:0] == 2'b00) ? 8'hFF : (lf[1:0] == 2'b01) ? 8'h00 :
                          (lf[2] ? 8'h55 : 8'hAA);
            end
            if (r % 2 == 0) put_sig(r % 36);
            run_case(r[1], r[2], 1'b0, $sformatf("rand%0d", r));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule